// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a simple synchronous request port and an asynchronous 256K x 8 DRAM with a multiplexed address bus. A request carries an 18-bit byte address, a write flag and write data. The controller splits the address into a 9-bit row (upper half) and a 9-bit column (lower half). It then drives the active-low row strobe, column strobe, write enable and output enable so that every minimum interval of the part is met. All intervals are counted in whole clock cycles.

Once a row is opened it stays open. A later request to the same row skips the row phase and runs only a column cycle. A request to another row first releases the row strobe for a precharge period and then opens the new row. If no request arrives for a set number of cycles, the open row is closed. The shared DRAM data bus is brought out as separate output, input and output-enable signals.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: During and after reset, ras_n, cas_n, we_n and oe_n are all high, dq_oe is low, ready is high and rsp_valid is low.
- R2: The DRAM address pins carry req_addr[17:9] when the row strobe falls and req_addr[8:0] when the column strobe falls.
- R3: A write drives dq_o with the request data and dq_oe high, keeps oe_n high, and pulls we_n low at least one cycle before the column strobe falls.
- R4: A read holds we_n high and dq_oe low and pulls oe_n low with the column strobe. The DRAM data is sampled exactly TCAC cycles after the column strobe falls and is returned on rsp_rdata with rsp_valid high for exactly one cycle.
- R5: A request whose row equals the open row produces no row-strobe edge and only a column-strobe cycle.
- R6: Successive falls of the row strobe are at least TRC cycles apart (default 11).
- R7: Successive falls of the column strobe are at least TPC cycles apart (default 4).
- R8: The column strobe falls at least TRAC-TCAC cycles after the row strobe falls (default 4), so data is sampled no earlier than TRAC cycles after the row strobe falls.
- R9: Before falling again, the row strobe stays high for at least PRE_CYC cycles (default 3). A request to a different row closes the open row before the new row is opened.
- R10: ready is low from the cycle after a request is accepted until that access has finished.
- R11: After IDLE_TO cycles (default 24) in the open-row state with no request, the row strobe is released. It stays low for fewer idle cycles than that.
- R12: The column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Byte address, row in upper half |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 8 | Read data |
| dram_addr_o | output | 9 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 8 | Data toward the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 8 | Data from the DRAM |

## Verification
The assertions assume that a requester holds req_valid_i and its request fields steady until the request is accepted. They also assume that the clock period is no shorter than the T_CLK_NS parameter, so that the interval counters stand for real time. The bench driver presents each request on a falling clock edge, holds it until a rising edge with ready high, then drops valid. It waits for ready to return before the next request. The DRAM model answers with data only while both strobes and output enable are low.

// File: rtl/pdram_pkg.sv
package pdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_WAIT,
    ST_RCD,
    ST_COL_SETUP,
    ST_COL_WAIT,
    ST_CAS,
    ST_OPEN
  } seq_state_e;

  localparam int unsigned GAP_RC  = 0;
  localparam int unsigned GAP_PRE = 1;
  localparam int unsigned GAP_PC  = 2;
  localparam int unsigned N_GAPS  = 3;

  // round a nanosecond limit up to whole clocks
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/pdram_gap_timer.sv
module pdram_gap_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '1;
    else if (restart_i)        cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  // next edge is at least LIMIT edges after the restart edge
  assign ok_o = (cnt_q >= CW'(LIMIT - 1));
endmodule

// File: rtl/pdram_req_latch.sv
module pdram_req_latch #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          ras_fall_i,
  input  logic [2*AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          row_hit_o
);
  logic [AW-1:0] open_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o   <= '0;
      col_o   <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else if (accept_i) begin
      row_o   <= addr_i[2*AW-1:AW];
      col_o   <= addr_i[AW-1:0];
      we_o    <= we_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         open_row_q <= '0;
    else if (ras_fall_i) open_row_q <= row_o;
  end

  assign row_hit_o = (addr_i[2*AW-1:AW] == open_row_q);
endmodule

// File: rtl/pdram_seq.sv
module pdram_seq
  import pdram_pkg::*;
#(
  parameter int unsigned AW      = 9,
  parameter int unsigned DW      = 8,
  parameter int unsigned RCD_CYC = 4,
  parameter int unsigned CAC_CYC = 2,
  parameter int unsigned IDLE_TO = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          row_hit_i,
  input  logic [AW-1:0] row_i,
  input  logic [AW-1:0] col_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rc_ok_i,
  input  logic          pre_ok_i,
  input  logic          pc_ok_i,
  input  logic [DW-1:0] dq_i,
  output logic          ready_o,
  output logic          accept_o,
  output logic          ras_fall_o,
  output logic          ras_rise_o,
  output logic          cas_fall_o,
  output logic [AW-1:0] addr_o,
  output logic          ras_no,
  output logic          cas_no,
  output logic          we_no,
  output logic          oe_no,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  localparam int unsigned WCW = $clog2(IDLE_TO + RCD_CYC + CAC_CYC + 2) + 1;

  seq_state_e    st_q, st_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic          ras_d, cas_d, we_d, oe_d, dq_oe_d, rsp_valid_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] dq_d, rsp_data_d;

  assign ready_o    = (st_q == ST_IDLE) || (st_q == ST_OPEN);
  assign accept_o   = req_valid_i && ready_o;
  assign ras_fall_o = ras_no && !ras_d;
  assign ras_rise_o = !ras_no && ras_d;
  assign cas_fall_o = cas_no && !cas_d;

  always_comb begin
    st_d        = st_q;
    wcnt_d      = wcnt_q + 1'b1;
    ras_d       = ras_no;
    cas_d       = cas_no;
    we_d        = we_no;
    oe_d        = oe_no;
    dq_oe_d     = dq_oe_o;
    addr_d      = addr_o;
    dq_d        = dq_o;
    rsp_valid_d = 1'b0;
    rsp_data_d  = rsp_data_o;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i) st_d = ST_ROW_WAIT;
      end
      ST_ROW_WAIT: begin
        if (rc_ok_i && pre_ok_i) begin
          ras_d   = 1'b0;
          addr_d  = row_i;
          we_d    = !we_i;
          dq_oe_d = we_i;
          dq_d    = wdata_i;
          wcnt_d  = '0;
          st_d    = ST_RCD;
        end
      end
      ST_RCD: begin
        // column address one cycle ahead of the strobe
        if (wcnt_q == WCW'(RCD_CYC - 2)) begin
          addr_d = col_i;
          st_d   = ST_COL_WAIT;
        end
      end
      ST_COL_SETUP: begin
        addr_d  = col_i;
        we_d    = !we_i;
        dq_oe_d = we_i;
        dq_d    = wdata_i;
        st_d    = ST_COL_WAIT;
      end
      ST_COL_WAIT: begin
        if (pc_ok_i) begin
          cas_d  = 1'b0;
          oe_d   = we_i;
          wcnt_d = '0;
          st_d   = ST_CAS;
        end
      end
      ST_CAS: begin
        if (wcnt_q == WCW'(CAC_CYC - 1)) begin
          cas_d   = 1'b1;
          oe_d    = 1'b1;
          we_d    = 1'b1;
          dq_oe_d = 1'b0;
          if (!we_i) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = dq_i;
          end
          wcnt_d = '0;
          st_d   = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (req_valid_i) begin
          wcnt_d = '0;
          if (row_hit_i) begin
            st_d = ST_COL_SETUP;
          end else begin
            ras_d = 1'b1;
            st_d  = ST_ROW_WAIT;
          end
        end else if (wcnt_q == WCW'(IDLE_TO - 1)) begin
          ras_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      wcnt_q      <= '0;
      ras_no      <= 1'b1;
      cas_no      <= 1'b1;
      we_no       <= 1'b1;
      oe_no       <= 1'b1;
      dq_oe_o     <= 1'b0;
      addr_o      <= '0;
      dq_o        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      st_q        <= st_d;
      wcnt_q      <= wcnt_d;
      ras_no      <= ras_d;
      cas_no      <= cas_d;
      we_no       <= we_d;
      oe_no       <= oe_d;
      dq_oe_o     <= dq_oe_d;
      addr_o      <= addr_d;
      dq_o        <= dq_d;
      rsp_valid_o <= rsp_valid_d;
      rsp_data_o  <= rsp_data_d;
    end
  end
endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl
  import pdram_pkg::*;
#(
  parameter int unsigned ADDR_PINS = 9,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_CLK_NS  = 10,
  parameter int unsigned T_RC_NS   = 110,
  parameter int unsigned T_RAC_NS  = 60,
  parameter int unsigned T_CAC_NS  = 15,
  parameter int unsigned T_PC_NS   = 35,
  parameter int unsigned PRE_CYC   = 3,
  parameter int unsigned IDLE_TO   = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_we_i,
  input  logic [2*ADDR_PINS-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   req_ready_o,
  output logic                   rsp_valid_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic [ADDR_PINS-1:0]   dram_addr_o,
  output logic                   dram_ras_no,
  output logic                   dram_cas_no,
  output logic                   dram_we_no,
  output logic                   dram_oe_no,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe_o,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  localparam int unsigned RC_CYC  = ns_to_cyc(T_RC_NS, T_CLK_NS);
  localparam int unsigned RAC_CYC = ns_to_cyc(T_RAC_NS, T_CLK_NS);
  localparam int unsigned CAC_CYC = ns_to_cyc(T_CAC_NS, T_CLK_NS);
  localparam int unsigned PC_CYC  = ns_to_cyc(T_PC_NS, T_CLK_NS);
  localparam int unsigned RCD_RAW = (RAC_CYC > CAC_CYC) ? RAC_CYC - CAC_CYC : 0;
  localparam int unsigned RCD_CYC = (RCD_RAW < 2) ? 2 : RCD_RAW;

  logic                 accept, ras_fall, ras_rise, cas_fall, row_hit, lat_we;
  logic [ADDR_PINS-1:0] lat_row, lat_col;
  logic [DATA_W-1:0]    lat_wdata;
  logic [N_GAPS-1:0]    gap_restart, gap_ok;

  assign gap_restart[GAP_RC]  = ras_fall;
  assign gap_restart[GAP_PRE] = ras_rise;
  assign gap_restart[GAP_PC]  = cas_fall;

  for (genvar g = 0; g < N_GAPS; g++) begin : g_gap
    localparam int unsigned LIM = (g == GAP_RC)  ? RC_CYC :
                                  (g == GAP_PRE) ? PRE_CYC : PC_CYC;
    pdram_gap_timer #(.LIMIT(LIM)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(gap_restart[g]),
      .ok_o     (gap_ok[g])
    );
  end

  pdram_req_latch #(.AW(ADDR_PINS), .DW(DATA_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .ras_fall_i(ras_fall),
    .addr_i    (req_addr_i),
    .we_i      (req_we_i),
    .wdata_i   (req_wdata_i),
    .row_o     (lat_row),
    .col_o     (lat_col),
    .we_o      (lat_we),
    .wdata_o   (lat_wdata),
    .row_hit_o (row_hit)
  );

  pdram_seq #(
    .AW     (ADDR_PINS),
    .DW     (DATA_W),
    .RCD_CYC(RCD_CYC),
    .CAC_CYC(CAC_CYC),
    .IDLE_TO(IDLE_TO)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .row_hit_i  (row_hit),
    .row_i      (lat_row),
    .col_i      (lat_col),
    .we_i       (lat_we),
    .wdata_i    (lat_wdata),
    .rc_ok_i    (gap_ok[GAP_RC]),
    .pre_ok_i   (gap_ok[GAP_PRE]),
    .pc_ok_i    (gap_ok[GAP_PC]),
    .dq_i       (dram_dq_i),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .ras_fall_o (ras_fall),
    .ras_rise_o (ras_rise),
    .cas_fall_o (cas_fall),
    .addr_o     (dram_addr_o),
    .ras_no     (dram_ras_no),
    .cas_no     (dram_cas_no),
    .we_no      (dram_we_no),
    .oe_no      (dram_oe_no),
    .dq_o       (dram_dq_o),
    .dq_oe_o    (dram_dq_oe_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_data_o (rsp_rdata_o)
  );
endmodule

// File: rtl/pdram_checker.sv
module pdram_checker
  import pdram_pkg::*;
#(
  parameter int unsigned T_CLK_NS = 10,
  parameter int unsigned T_RC_NS  = 110,
  parameter int unsigned T_RAC_NS = 60,
  parameter int unsigned T_CAC_NS = 15,
  parameter int unsigned T_PC_NS  = 35,
  parameter int unsigned PRE_CYC  = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic dram_ras_no,
  input logic dram_cas_no,
  input logic dram_we_no,
  input logic dram_oe_no,
  input logic dram_dq_oe_o
);
  localparam int unsigned RC  = ns_to_cyc(T_RC_NS, T_CLK_NS);
  localparam int unsigned CAC = ns_to_cyc(T_CAC_NS, T_CLK_NS);
  localparam int unsigned PC  = ns_to_cyc(T_PC_NS, T_CLK_NS);
  localparam int unsigned RAC = ns_to_cyc(T_RAC_NS, T_CLK_NS);
  localparam int unsigned RCD = (RAC > CAC + 2) ? RAC - CAC : 2;
  localparam int unsigned CW  = $clog2(RC + PC + PRE_CYC + RAC + 2) + 1;

  logic          ras_prev, cas_prev;
  logic [CW-1:0] since_rf, since_rr, since_cf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_prev <= 1'b1;
      cas_prev <= 1'b1;
      since_rf <= '1;
      since_rr <= '1;
      since_cf <= '1;
    end else begin
      ras_prev <= dram_ras_no;
      cas_prev <= dram_cas_no;
      if (ras_prev && !dram_ras_no) since_rf <= '0;
      else if (since_rf != '1)      since_rf <= since_rf + 1'b1;
      if (!ras_prev && dram_ras_no) since_rr <= '0;
      else if (since_rr != '1)      since_rr <= since_rr + 1'b1;
      if (cas_prev && !dram_cas_no) since_cf <= '0;
      else if (since_cf != '1)      since_cf <= since_cf + 1'b1;
    end
  end

  a_r6_trc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> since_rf >= CW'(RC - 1));
  a_r9_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> since_rr >= CW'(PRE_CYC - 1));
  a_r7_tpc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> since_cf >= CW'(PC - 1));
  a_r8_ras_to_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> since_rf >= CW'(RCD - 1));
  a_r12_cas_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  a_r3_write_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> dram_oe_no && dram_dq_oe_o);
  a_r3_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && dram_dq_oe_o |-> $past(!dram_we_no));
  a_r4_read_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> !dram_dq_oe_o && dram_we_no);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r4_tcac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> since_cf == CW'(CAC - 1));
  a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
endmodule

bind pagemode_dram_ctrl pdram_checker #(
  .T_CLK_NS(T_CLK_NS),
  .T_RC_NS (T_RC_NS),
  .T_RAC_NS(T_RAC_NS),
  .T_CAC_NS(T_CAC_NS),
  .T_PC_NS (T_PC_NS),
  .PRE_CYC (PRE_CYC)
) u_pdram_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .dram_ras_no (dram_ras_no),
  .dram_cas_no (dram_cas_no),
  .dram_we_no  (dram_we_no),
  .dram_oe_no  (dram_oe_no),
  .dram_dq_oe_o(dram_dq_oe_o)
);

// File: tb/pagemode_dram_ctrl_bench.sv
module pagemode_dram_ctrl_bench;
  localparam int TRC = 11, TPRE = 3, TPC = 4, TCAC = 2, TRCD = 4, IDLE_TO = 24;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata, dram_dq_o, dram_dq_i;
  logic [8:0]  dram_addr;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;

  always #5 clk = ~clk;

  pagemode_dram_ctrl u_pagemode_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .dram_addr_o(dram_addr),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_dq_o(dram_dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dram_dq_i)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic logic [7:0] fill(input int a);
    return a[7:0] ^ a[17:10] ^ 8'h5A;
  endfunction

  // DRAM model and scoreboard state
  logic [7:0] mem_q [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];
  logic [8:0] m_row = '0, m_col = '0;
  logic [7:0] rd_byte = '0;
  logic [8:0] cur_row = '0, cur_col = '0;
  logic [7:0] cur_wd = '0;
  bit         cur_we = 1'b0;

  assign dram_dq_i = (!ras_n && !cas_n && !oe_n) ? rd_byte : 8'h00;

  int  cyc = 0, last_rf = 0, last_rr = 0, last_cf = 0, ras_falls = 0, ras_rises = 0;
  bit  have_rf = 0, have_rr = 0, have_cf = 0;
  logic prev_ras = 1, prev_cas = 1, prev_we = 1, prev_rsp = 0;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        if (have_rf) check(cyc - last_rf >= TRC, "R6 row cycle", cyc - last_rf, TRC);
        if (have_rr) check(cyc - last_rr >= TPRE, "R9 precharge", cyc - last_rr, TPRE);
        check(dram_addr == cur_row, "R2 row addr", dram_addr, cur_row);
        m_row   = dram_addr;
        last_rf = cyc;
        have_rf = 1;
      end
      if (!prev_ras && ras_n) begin
        ras_rises++;
        last_rr = cyc;
        have_rr = 1;
      end
      if (!cas_n) check(!ras_n, "R12 cas inside row", ras_n, 0);
      if (prev_cas && !cas_n) begin
        check(cyc - last_rf >= TRCD, "R8 ras to cas", cyc - last_rf, TRCD);
        if (have_cf) check(cyc - last_cf >= TPC, "R7 column cycle", cyc - last_cf, TPC);
        check(dram_addr == cur_col, "R2 col addr", dram_addr, cur_col);
        m_col   = dram_addr;
        last_cf = cyc;
        have_cf = 1;
        if (cur_we) begin
          check(!prev_we && !we_n && dq_oe && oe_n, "R3 early write strobes",
                {prev_we, we_n, dq_oe, oe_n}, 4'b0011);
          check(dram_dq_o == cur_wd, "R3 write data", dram_dq_o, cur_wd);
          mem_q[int'({m_row, m_col})] = dram_dq_o;
        end else begin
          check(we_n && !oe_n && !dq_oe, "R4 read strobes", {we_n, oe_n, dq_oe}, 3'b100);
          rd_byte = mem_q.exists(int'({m_row, m_col})) ? mem_q[int'({m_row, m_col})]
                                                        : fill(int'({m_row, m_col}));
        end
      end
      if (rsp_valid) begin
        check(!prev_rsp, "R4 single pulse", prev_rsp, 0);
        check(cyc - last_cf == TCAC, "R4 sample delay", cyc - last_cf, TCAC);
        if (exp_q.size() == 0) check(0, "R4 unexpected response", rsp_rdata, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(rsp_rdata == e, "R4 read data", rsp_rdata, e);
        end
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
      prev_we  = we_n;
      prev_rsp = rsp_valid;
    end
  end

  // driver
  task automatic do_req(input bit we, input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_row   = a[17:9];
    cur_col   = a[8:0];
    cur_we    = we;
    cur_wd    = d;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    if (we) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : fill(int'(a)));
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10 busy after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n0, r0;
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n && !dq_oe && req_ready && !rsp_valid,
          "R1 reset state", {ras_n, cas_n, we_n, oe_n, dq_oe, req_ready, rsp_valid}, 7'b1111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n && !dq_oe && req_ready && !rsp_valid,
          "R1 after release", {ras_n, cas_n, we_n, oe_n, dq_oe, req_ready, rsp_valid}, 7'b1111010);

    do_req(1'b1, {9'h005, 9'h00A}, 8'h3C);
    n0 = ras_falls;
    r0 = ras_rises;
    do_req(1'b0, {9'h005, 9'h00A}, 8'h00);
    do_req(1'b1, {9'h005, 9'h1FF}, 8'hC3);
    do_req(1'b0, {9'h005, 9'h1FF}, 8'h00);
    do_req(1'b0, {9'h005, 9'h000}, 8'h00);
    check(ras_falls == n0 && ras_rises == r0, "R5 page hits keep row", ras_falls - n0, 0);
    check(!ras_n, "R5 row still open", ras_n, 0);

    do_req(1'b0, {9'h1FF, 9'h000}, 8'h00);
    check(ras_falls == n0 + 1 && ras_rises == r0 + 1, "R9 miss reopens row", ras_falls - n0, 1);
    do_req(1'b0, {9'h005, 9'h00A}, 8'h00);
    for (int k = 0; k < 4; k++)
      do_req(k[0], {(k[0] ? 9'h041 : 9'h040), 9'(k)}, 8'(8'hA0 + k));
    do_req(1'b0, {9'h041, 9'h001}, 8'h00);

    repeat (IDLE_TO - 3) @(negedge clk);
    check(!ras_n, "R11 row held before timeout", ras_n, 0);
    repeat (6) @(negedge clk);
    check(ras_n, "R11 row closed after timeout", ras_n, 1);

    do_req(1'b0, {9'h005, 9'h1FF}, 8'h00);
    do_req(1'b1, {9'h0AA, 9'h155}, 8'h99);
    do_req(1'b0, {9'h0AA, 9'h155}, 8'h00);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule